// File: doc/BRIEF.md
# Prescaled Real-Time Counter Timebase

This block is the counting core of a low-frequency real-time counter. A 15-bit pre-counter and a 32-bit main counter both run on one slow clock. The main counter advances from one of two sources. The first is a power-of-two prescaler, selected by a 4-bit code. The second is a compare match, which fires when the pre-counter equals the low 15 bits of the channel 0 compare value. Each counter has an optional top value that makes it wrap early. The pre-counter's top value comes from channel 0 and the main counter's top value comes from channel 1.

Start and stop command pulses control the running state. A debug-halt input freezes both counters unless debug running is enabled. Software can write either counter directly. The block drives out both counter values and a 32-bit combined view, which holds the pre-counter in the low 15 bits and the low 17 main-counter bits above it. It also drives a running status and two single-cycle event pulses, one for a main-counter tick and one for a main-counter overflow.

Top module: `rtc_timebase`

## Requirements
- R1: After synchronous reset, both counters, the combined view, `running_o`, `tick_o` and `ovf_o` are all 0.
- R2: A `start_i` pulse sets `running_o` at the next clock edge and a `stop_i` pulse clears it. When both are high in the same cycle, stop wins.
- R3: With `tick_sel_i`=0, the main counter advances once every 2^n active cycles, where n is `presc_code_i` (0 means every cycle). The prescaler phase restarts on each start command, so the first advance lands on the 2^n-th active edge after the start edge.
- R4: With `tick_sel_i`=1, the main counter advances at each active edge where the pre-counter equals `ch0_cmp_i[14:0]`.
- R5: With `pre_top_en_i`=1, the pre-counter goes to 0, instead of incrementing, at an active edge where it equals `ch0_cmp_i[14:0]`.
- R6: With `main_top_en_i`=1, an advance while the main counter equals `ch1_cmp_i` loads 0 and pulses `ovf_o`.
- R7: An advance from 32'hFFFFFFFF wraps the main counter to 0 and pulses `ovf_o`.
- R8: `comb_cnt_o` equals the main counter bits [16:0] in bits [31:15], with the pre-counter in bits [14:0].
- R9: While `dbg_halt_i`=1 and `dbg_run_i`=0, both counters hold. With `dbg_run_i`=1 they keep counting.
- R10: A write (`pre_wr_i` or `main_wr_i`) loads its data at the next edge in place of that cycle's increment. A main-counter write produces no `tick_o` or `ovf_o` in that cycle.
- R11: `tick_o` is high for exactly the one cycle in which the main counter shows a newly advanced value.
- R12: While not running, neither counter changes except by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counting clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| dbg_halt_i | input | 1 | Debug halt request |
| dbg_run_i | input | 1 | 1: keep counting during debug halt |
| tick_sel_i | input | 1 | 0: prescaler advances main counter, 1: pre-counter match does |
| presc_code_i | input | 4 | Prescaler exponent n (divide by 2^n) |
| pre_top_en_i | input | 1 | Enable pre-counter wrap at channel 0 compare |
| main_top_en_i | input | 1 | Enable main-counter wrap at channel 1 compare |
| ch0_cmp_i | input | 32 | Channel 0 compare value |
| ch1_cmp_i | input | 32 | Channel 1 compare value |
| pre_wr_i | input | 1 | Pre-counter write strobe |
| pre_wdata_i | input | 15 | Pre-counter write data |
| main_wr_i | input | 1 | Main-counter write strobe |
| main_wdata_i | input | 32 | Main-counter write data |
| pre_cnt_o | output | 15 | Pre-counter value |
| main_cnt_o | output | 32 | Main-counter value |
| comb_cnt_o | output | 32 | Combined view of the two counters |
| running_o | output | 1 | Running status |
| tick_o | output | 1 | Main-counter advance event |
| ovf_o | output | 1 | Main-counter wrap event |

## Verification
A wrong prescaler phase shows up at the ports as a `tick_o` pulse and main-counter step that land early or late. The bench checks the exact cycle of the first advance after start, and that error appears within 2^n cycles. A wrong top compare or wrap decision shows up on the very next active edge, as a counter value that is not zero together with a missing or extra `ovf_o`. A wrong run or halt state shows up one edge after the command, as counters that move when they should hold or hold when they should move.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
    localparam int PRE_W  = 15;
    localparam int MAIN_W = 32;
    localparam int CODE_W = $clog2(PRE_W + 1);

    typedef enum logic {
        ADV_PRESC = 1'b0,
        ADV_MATCH = 1'b1
    } adv_src_e;

    typedef struct packed {
        logic active;
        logic restart;
    } run_ctl_t;
endpackage

// File: rtl/rtcb_divider.sv
module rtcb_divider #(
    parameter int PRE_W  = rtcb_pkg::PRE_W,
    parameter int CODE_W = rtcb_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  rtcb_pkg::run_ctl_t ctl,
    input  logic [CODE_W-1:0] code,
    output logic              fire
);
    logic [PRE_W-1:0] phase;
    logic [PRE_W:0]   weight;
    logic [PRE_W-1:0] mask;

    always_comb begin
        weight = (PRE_W + 1)'(1) << code;
        mask   = weight[PRE_W-1:0] - PRE_W'(1);
        fire   = ctl.active && ((phase & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            phase <= '0;
        end else if (ctl.active) begin
            phase <= phase + PRE_W'(1);
        end
    end
endmodule

// File: rtl/rtcb_precnt.sv
module rtcb_precnt #(
    parameter int PRE_W = rtcb_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             wr,
    input  logic [PRE_W-1:0] wdata,
    input  logic             top_en,
    input  logic [PRE_W-1:0] cmp,
    output logic             hit,
    output logic [PRE_W-1:0] cnt
);
    always_comb hit = (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= wdata;
        end else if (active) begin
            if (top_en && hit) cnt <= '0;
            else               cnt <= cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/rtcb_maincnt.sv
module rtcb_maincnt #(
    parameter int MAIN_W = rtcb_pkg::MAIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr,
    input  logic [MAIN_W-1:0] wdata,
    input  logic              top_en,
    input  logic [MAIN_W-1:0] top_val,
    output logic [MAIN_W-1:0] cnt,
    output logic              tick_ev,
    output logic              ovf_ev
);
    localparam logic [MAIN_W-1:0] ALL_ONES = '1;

    logic wrap;
    always_comb wrap = (top_en && cnt == top_val) || (cnt == ALL_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            tick_ev <= 1'b0;
            ovf_ev  <= 1'b0;
        end else begin
            tick_ev <= step && !wr;
            ovf_ev  <= step && !wr && wrap;
            if (wr) begin
                cnt <= wdata;
            end else if (step) begin
                cnt <= wrap ? '0 : cnt + MAIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtcb_pkg::*;
#(
    parameter int PW = rtcb_pkg::PRE_W,
    parameter int MW = rtcb_pkg::MAIN_W,
    parameter int CW = rtcb_pkg::CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          dbg_halt_i,
    input  logic          dbg_run_i,
    input  logic          tick_sel_i,
    input  logic [CW-1:0] presc_code_i,
    input  logic          pre_top_en_i,
    input  logic          main_top_en_i,
    input  logic [MW-1:0] ch0_cmp_i,
    input  logic [MW-1:0] ch1_cmp_i,
    input  logic          pre_wr_i,
    input  logic [PW-1:0] pre_wdata_i,
    input  logic          main_wr_i,
    input  logic [MW-1:0] main_wdata_i,
    output logic [PW-1:0] pre_cnt_o,
    output logic [MW-1:0] main_cnt_o,
    output logic [MW-1:0] comb_cnt_o,
    output logic          running_o,
    output logic          tick_o,
    output logic          ovf_o
);
    localparam int HI_W = MW - PW;

    logic     running;
    run_ctl_t ctl;
    adv_src_e src;
    logic     div_fire;
    logic     pre_hit;
    logic     step;

    always_ff @(posedge clk) begin
        if (rst)          running <= 1'b0;
        else if (stop_i)  running <= 1'b0;
        else if (start_i) running <= 1'b1;
    end

    always_comb begin
        ctl.active  = running && !(dbg_halt_i && !dbg_run_i);
        ctl.restart = start_i && !stop_i;
        src         = adv_src_e'(tick_sel_i);
        step        = (src == ADV_MATCH) ? (ctl.active && pre_hit) : div_fire;
    end

    rtcb_divider #(.PRE_W(PW), .CODE_W(CW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .code (presc_code_i),
        .fire (div_fire)
    );

    rtcb_precnt #(.PRE_W(PW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (ctl.active),
        .wr     (pre_wr_i),
        .wdata  (pre_wdata_i),
        .top_en (pre_top_en_i),
        .cmp    (ch0_cmp_i[PW-1:0]),
        .hit    (pre_hit),
        .cnt    (pre_cnt_o)
    );

    rtcb_maincnt #(.MAIN_W(MW)) u_main (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wr      (main_wr_i),
        .wdata   (main_wdata_i),
        .top_en  (main_top_en_i),
        .top_val (ch1_cmp_i),
        .cnt     (main_cnt_o),
        .tick_ev (tick_o),
        .ovf_ev  (ovf_o)
    );

    assign comb_cnt_o = {main_cnt_o[HI_W-1:0], pre_cnt_o};
    assign running_o  = running;
endmodule

// File: rtl/rtcb_checker.sv
module rtcb_checker #(
    parameter int PW = rtcb_pkg::PRE_W,
    parameter int MW = rtcb_pkg::MAIN_W
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          stop_i,
    input logic          dbg_halt_i,
    input logic          dbg_run_i,
    input logic          pre_wr_i,
    input logic          main_wr_i,
    input logic [MW-1:0] main_wdata_i,
    input logic [PW-1:0] pre_cnt_o,
    input logic [MW-1:0] main_cnt_o,
    input logic          running_o,
    input logic          tick_o,
    input logic          ovf_o
);
    // R2: stop wins
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !running_o);
    // R2: start alone sets running
    a_r2_start_sets: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stop_i) |=> running_o);
    // R6/R7: overflow only with a tick and a zero count
    a_r7_ovf_at_zero: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (tick_o && main_cnt_o == '0));
    // R11: a tick shows a count one above the last, or a wrap to zero
    a_r11_tick_step: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (main_cnt_o == $past(main_cnt_o) + MW'(1) || main_cnt_o == '0));
    // R10: main write loads data
    a_r10_main_write: assert property (@(posedge clk) disable iff (rst)
        main_wr_i |=> (main_cnt_o == $past(main_wdata_i) && !tick_o));
    // R12: stopped pre-counter holds
    a_r12_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!running_o && !pre_wr_i && !main_wr_i) |=> ($stable(pre_cnt_o) && $stable(main_cnt_o)));
    // R9: debug halt freezes
    a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (dbg_halt_i && !dbg_run_i && !pre_wr_i && !main_wr_i) |=> ($stable(pre_cnt_o) && $stable(main_cnt_o)));
endmodule

bind rtc_timebase rtcb_checker #(.PW(PW), .MW(MW)) u_chk (.*);

// File: tb/tb_rtc_timebase.sv
module tb_rtc_timebase;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, stop_i, dbg_halt_i, dbg_run_i, tick_sel_i;
    logic [3:0]  presc_code_i;
    logic        pre_top_en_i, main_top_en_i;
    logic [31:0] ch0_cmp_i, ch1_cmp_i;
    logic        pre_wr_i, main_wr_i;
    logic [14:0] pre_wdata_i;
    logic [31:0] main_wdata_i;
    logic [14:0] pre_cnt_o;
    logic [31:0] main_cnt_o, comb_cnt_o;
    logic        running_o, tick_o, ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    rtc_timebase dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; start_i = 0; stop_i = 0; dbg_halt_i = 0; dbg_run_i = 0;
        tick_sel_i = 0; presc_code_i = 0; pre_top_en_i = 0; main_top_en_i = 0;
        ch0_cmp_i = 0; ch1_cmp_i = 0; pre_wr_i = 0; main_wr_i = 0;
        pre_wdata_i = 0; main_wdata_i = 0;
        cyc(2);
        rst = 0;
        cyc(1);
    endtask

    task automatic start_run();
        start_i = 1; cyc(1); start_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        eq("R1 pre", 32'(pre_cnt_o), 0);
        eq("R1 main", main_cnt_o, 0);
        eq("R1 comb", comb_cnt_o, 0);
        eq("R1 flags", {29'd0, running_o, tick_o, ovf_o}, 0);
    endtask

    task automatic t_run_ctl();
        do_reset();
        start_run();
        eq("R2 start", 32'(running_o), 1);
        stop_i = 1; cyc(1); stop_i = 0;
        eq("R2 stop", 32'(running_o), 0);
        start_i = 1; stop_i = 1; cyc(1); start_i = 0; stop_i = 0;
        eq("R2 stop priority", 32'(running_o), 0);
    endtask

    task automatic t_presc();
        do_reset();
        presc_code_i = 2;
        start_run();
        cyc(3);
        eq("R3 div4 before", main_cnt_o, 0);
        cyc(1);
        eq("R3 div4 first", main_cnt_o, 1);
        eq("R11 tick high", 32'(tick_o), 1);
        cyc(1);
        eq("R11 tick single", 32'(tick_o), 0);
        cyc(3);
        eq("R3 div4 second", main_cnt_o, 2);
        do_reset();
        presc_code_i = 4;
        start_run();
        cyc(15);
        eq("R3 div16 before", main_cnt_o, 0);
        cyc(1);
        eq("R3 div16 first", main_cnt_o, 1);
        do_reset();
        start_run();
        cyc(5);
        eq("R3 div1", main_cnt_o, 5);
    endtask

    task automatic t_match();
        do_reset();
        tick_sel_i = 1; ch0_cmp_i = 32'hABCD_0004;
        start_run();
        cyc(4);
        eq("R4 before match", main_cnt_o, 0);
        cyc(1);
        eq("R4 on match", main_cnt_o, 1);
        eq("R4 pre continues", 32'(pre_cnt_o), 5);
    endtask

    task automatic t_pre_top();
        do_reset();
        tick_sel_i = 1; pre_top_en_i = 1; ch0_cmp_i = 3;
        start_run();
        cyc(4);
        eq("R5 pre wrapped", 32'(pre_cnt_o), 0);
        eq("R5 main on wrap", main_cnt_o, 1);
        cyc(2);
        eq("R5 pre after wrap", 32'(pre_cnt_o), 2);
        cyc(2);
        eq("R5 second period", main_cnt_o, 2);
    endtask

    task automatic t_main_top();
        do_reset();
        main_top_en_i = 1; ch1_cmp_i = 2;
        start_run();
        cyc(2);
        eq("R6 at top", main_cnt_o, 2);
        eq("R6 no ovf yet", 32'(ovf_o), 0);
        cyc(1);
        eq("R6 wrapped", main_cnt_o, 0);
        eq("R6 ovf", 32'(ovf_o), 1);
    endtask

    task automatic t_overflow_write();
        do_reset();
        start_run();
        cyc(2);
        main_wr_i = 1; main_wdata_i = 32'hFFFF_FFFE;
        pre_wr_i = 1; pre_wdata_i = 15'h0100;
        cyc(1);
        main_wr_i = 0; pre_wr_i = 0;
        eq("R10 main write wins", main_cnt_o, 32'hFFFF_FFFE);
        eq("R10 no tick on write", 32'(tick_o), 0);
        eq("R10 pre write wins", 32'(pre_cnt_o), 32'h100);
        cyc(1);
        eq("R7 all ones", main_cnt_o, 32'hFFFF_FFFF);
        eq("R7 no ovf", 32'(ovf_o), 0);
        cyc(1);
        eq("R7 wrap", main_cnt_o, 0);
        eq("R7 ovf", 32'(ovf_o), 1);
    endtask

    task automatic t_comb();
        do_reset();
        pre_wr_i = 1; pre_wdata_i = 15'h1234;
        main_wr_i = 1; main_wdata_i = 32'h0001_ABCD;
        cyc(1);
        pre_wr_i = 0; main_wr_i = 0;
        eq("R8 comb", comb_cnt_o, (32'h0001_ABCD << 15) | 32'h1234);
    endtask

    task automatic t_debug();
        do_reset();
        start_run();
        cyc(2);
        eq("R9 counting", main_cnt_o, 2);
        dbg_halt_i = 1;
        cyc(3);
        eq("R9 main frozen", main_cnt_o, 2);
        eq("R9 pre frozen", 32'(pre_cnt_o), 2);
        dbg_run_i = 1;
        cyc(3);
        eq("R9 debug run", main_cnt_o, 5);
        dbg_halt_i = 0; dbg_run_i = 0;
    endtask

    task automatic t_stopped();
        logic [31:0] m;
        logic [14:0] p;
        do_reset();
        start_run();
        cyc(3);
        stop_i = 1; cyc(1); stop_i = 0;
        m = main_cnt_o; p = pre_cnt_o;
        eq("R12 last count", m, 4);
        cyc(5);
        eq("R12 main holds", main_cnt_o, m);
        eq("R12 pre holds", 32'(pre_cnt_o), 32'(p));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_run_ctl();
        t_presc();
        t_match();
        t_pre_top();
        t_main_top();
        t_overflow_write();
        t_comb();
        t_debug();
        t_stopped();
        finish_run();
    end

    initial begin
        #(PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule